// File: doc/BRIEF.md
# Modulator Command Packet Parser

This block sits between a host byte stream and an OFDM modulator. The host sends packets of bytes. Each packet holds typed blocks, and each block opens with one identifier byte. A packet may carry any mix of blocks in any order: settings only, payload only, or both. The parser turns each block into one of three kinds of output. Setting blocks become one-cycle write strobes for the active-subcarrier count and the guard length. Table blocks become writes into the per-subcarrier configuration table. Payload blocks are passed straight through to the symbol mapper.

Settings live downstream, so they persist from one packet to the next. A table item carries a base address byte and a configuration byte. The configuration byte holds two 4-bit settings, so one item writes two neighbouring table entries in one cycle. An unknown identifier raises a one-cycle error pulse, and the parser then drops the rest of that packet. The packet-last flag always brings the parser back to expecting an identifier, even if a block was cut short.

Top module: `cmdpkt_parser`

## Requirements
- R1: After reset all write strobes, `bad_id` and `dat_valid` are low, `in_ready` is high, and the first accepted byte is taken as a block identifier.
- R2: Identifier 0x01 is followed by a low byte and then a high byte. One cycle after the high byte is accepted, `ncar_we` pulses for one cycle and `ncar_val` equals the low 9 bits of {high, low}.
- R3: Identifier 0x03 is followed by two bytes, low byte first. One cycle after the second byte is accepted, `guard_we` pulses for one cycle and `guard_val` equals the low 9 bits of {high, low}.
- R4: Identifier 0x02 is followed by a count byte N and then N items of (address, configuration). One cycle after each configuration byte is accepted, `tbl_we` = 2'b11 and `tbl_addr` = address. `tbl_cfg` bits [3:0] are the setting for entry `address` and bits [7:4] are the setting for entry `address`+1.
- R5: An item whose address is 255 (the last entry) writes only the low setting: `tbl_we` = 2'b01.
- R6: Identifier 0x04 is followed by a count byte N and then N payload bytes. Each payload byte appears on `dat_byte` with `dat_valid` in the same cycle it is offered. While payload is flowing, `in_ready` equals `dat_ready`.
- R7: A count of zero in a table block or a payload block ends that block, and the next byte is an identifier.
- R8: Any identifier other than 0x01 to 0x04 pulses `bad_id` one cycle after it is accepted. The bytes that follow, up to and including the one flagged last, produce no strobe and no payload. The next packet is parsed normally.
- R9: A byte accepted with `in_last` high returns the parser to expecting an identifier, even in the middle of a block. A field that this byte completes still takes effect.
- R10: At most one of `ncar_we`, `guard_we`, any `tbl_we` bit and `bad_id` is high in a cycle. No strobe occurs other than those that R2 to R8 describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte ends the packet |
| in_ready | output | 1 | Parser accepts the input byte |
| dat_valid | output | 1 | Payload byte present for the mapper |
| dat_byte | output | 8 | Payload byte |
| dat_ready | input | 1 | Mapper accepts the payload byte |
| ncar_we | output | 1 | Active-subcarrier count write strobe |
| ncar_val | output | 9 | Active-subcarrier count value |
| guard_we | output | 1 | Guard length write strobe |
| guard_val | output | 9 | Guard length value |
| tbl_we | output | 2 | Table write enable per setting lane (lane k writes entry tbl_addr+k) |
| tbl_addr | output | 8 | Table base entry |
| tbl_cfg | output | 8 | Two 4-bit settings, lane 0 in the low bits |
| bad_id | output | 1 | Unknown identifier pulse |

## Verification
The packet-last flag can arrive in the same cycle as a byte that completes a field or forwards a payload byte. The block must then both carry out that final action and reset its parsing. The bench provokes this in three ways: a payload block cut short by the flag, a count field cut short, and an unknown identifier that carries the flag itself. It judges the result in two steps. A scoreboard first confirms that the completed action, or the error pulse, was produced. It then checks that the first byte of the following packet is decoded as an identifier, so any mis-parse shows up as an unexpected strobe.

// File: rtl/cmdpkt_pkg.sv
package cmdpkt_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] ID_NCAR  = 8'h01;
    localparam logic [BYTE_W-1:0] ID_MOD   = 8'h02;
    localparam logic [BYTE_W-1:0] ID_GUARD = 8'h03;
    localparam logic [BYTE_W-1:0] ID_DATA  = 8'h04;

    typedef enum logic [3:0] {
        S_ID,
        S_NC_LO,
        S_NC_HI,
        S_GD_LO,
        S_GD_HI,
        S_MOD_CNT,
        S_MOD_ADR,
        S_MOD_CFG,
        S_DAT_CNT,
        S_DAT_PAY,
        S_DROP
    } pstate_t;

    // Decoded action for the byte accepted in this cycle.
    typedef struct packed {
        logic                  ncar;
        logic                  guard;
        logic                  tbl;
        logic                  bad;
        logic [2*BYTE_W-1:0]   val;
        logic [BYTE_W-1:0]     addr;
        logic [BYTE_W-1:0]     cfg;
    } pevt_t;

    function automatic logic lane_in_range(input logic [BYTE_W-1:0] base,
                                           input int lane, input int nsub);
        return (int'(base) + lane) < nsub;
    endfunction

endpackage

// File: rtl/cmdpkt_fsm.sv
module cmdpkt_fsm
    import cmdpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    input  logic              dat_ready,
    output logic              in_ready,
    output logic              dat_valid,
    output logic [BYTE_W-1:0] dat_byte,
    output pevt_t             evt
);

    pstate_t           st_q, st_n;
    logic [BYTE_W-1:0] lo_q, lo_n;
    logic [BYTE_W-1:0] cnt_q, cnt_n;
    logic [BYTE_W-1:0] adr_q, adr_n;
    logic              acc;

    assign in_ready  = (st_q == S_DAT_PAY) ? dat_ready : 1'b1;
    assign acc       = in_valid && in_ready;
    assign dat_valid = in_valid && (st_q == S_DAT_PAY);
    assign dat_byte  = in_data;

    always_comb begin
        st_n     = st_q;
        lo_n     = lo_q;
        cnt_n    = cnt_q;
        adr_n    = adr_q;
        evt      = '0;
        evt.val  = {in_data, lo_q};
        evt.addr = adr_q;
        evt.cfg  = in_data;
        if (acc) begin
            case (st_q)
                S_ID: begin
                    case (in_data)
                        ID_NCAR:  st_n = S_NC_LO;
                        ID_MOD:   st_n = S_MOD_CNT;
                        ID_GUARD: st_n = S_GD_LO;
                        ID_DATA:  st_n = S_DAT_CNT;
                        default: begin
                            evt.bad = 1'b1;
                            st_n    = S_DROP;
                        end
                    endcase
                end
                S_NC_LO: begin
                    lo_n = in_data;
                    st_n = S_NC_HI;
                end
                S_NC_HI: begin
                    evt.ncar = 1'b1;
                    st_n     = S_ID;
                end
                S_GD_LO: begin
                    lo_n = in_data;
                    st_n = S_GD_HI;
                end
                S_GD_HI: begin
                    evt.guard = 1'b1;
                    st_n      = S_ID;
                end
                S_MOD_CNT: begin
                    cnt_n = in_data;
                    st_n  = (in_data == '0) ? S_ID : S_MOD_ADR;
                end
                S_MOD_ADR: begin
                    adr_n = in_data;
                    st_n  = S_MOD_CFG;
                end
                S_MOD_CFG: begin
                    evt.tbl = 1'b1;
                    cnt_n   = cnt_q - 1'b1;
                    st_n    = (cnt_q == 8'd1) ? S_ID : S_MOD_ADR;
                end
                S_DAT_CNT: begin
                    cnt_n = in_data;
                    st_n  = (in_data == '0) ? S_ID : S_DAT_PAY;
                end
                S_DAT_PAY: begin
                    cnt_n = cnt_q - 1'b1;
                    st_n  = (cnt_q == 8'd1) ? S_ID : S_DAT_PAY;
                end
                default: st_n = S_DROP;
            endcase
            if (in_last) begin
                st_n = S_ID;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_ID;
            lo_q  <= '0;
            cnt_q <= '0;
            adr_q <= '0;
        end else begin
            st_q  <= st_n;
            lo_q  <= lo_n;
            cnt_q <= cnt_n;
            adr_q <= adr_n;
        end
    end

endmodule

// File: rtl/cmdpkt_wr.sv
module cmdpkt_wr
    import cmdpkt_pkg::*;
#(
    parameter int NSUB   = 256,
    parameter int CFG_W  = 4,
    parameter int LANES  = 2,
    parameter int VAL_W  = 9,
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  pevt_t                  evt,
    output logic                   ncar_we,
    output logic [VAL_W-1:0]       ncar_val,
    output logic                   guard_we,
    output logic [VAL_W-1:0]       guard_val,
    output logic [LANES-1:0]       tbl_we,
    output logic [ADDR_W-1:0]      tbl_addr,
    output logic [LANES*CFG_W-1:0] tbl_cfg,
    output logic                   bad_id
);

    logic [LANES-1:0] lane_ok;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_ok[k] = evt.tbl && lane_in_range(evt.addr, k, NSUB);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ncar_we   <= 1'b0;
            guard_we  <= 1'b0;
            tbl_we    <= '0;
            bad_id    <= 1'b0;
            ncar_val  <= '0;
            guard_val <= '0;
            tbl_addr  <= '0;
            tbl_cfg   <= '0;
        end else begin
            ncar_we  <= evt.ncar;
            guard_we <= evt.guard;
            tbl_we   <= lane_ok;
            bad_id   <= evt.bad;
            if (evt.ncar) begin
                ncar_val <= evt.val[VAL_W-1:0];
            end
            if (evt.guard) begin
                guard_val <= evt.val[VAL_W-1:0];
            end
            if (evt.tbl) begin
                tbl_addr <= evt.addr[ADDR_W-1:0];
                tbl_cfg  <= evt.cfg[LANES*CFG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/cmdpkt_parser.sv
module cmdpkt_parser
    import cmdpkt_pkg::*;
#(
    parameter  int NSUB   = 256,
    parameter  int CFG_W  = 4,
    localparam int LANES  = BYTE_W / CFG_W,
    localparam int VAL_W  = $clog2(NSUB + 1),
    localparam int ADDR_W = $clog2(NSUB)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [BYTE_W-1:0]      in_data,
    input  logic                   in_last,
    output logic                   in_ready,
    output logic                   dat_valid,
    output logic [BYTE_W-1:0]      dat_byte,
    input  logic                   dat_ready,
    output logic                   ncar_we,
    output logic [VAL_W-1:0]       ncar_val,
    output logic                   guard_we,
    output logic [VAL_W-1:0]       guard_val,
    output logic [LANES-1:0]       tbl_we,
    output logic [ADDR_W-1:0]      tbl_addr,
    output logic [LANES*CFG_W-1:0] tbl_cfg,
    output logic                   bad_id
);

    pevt_t evt;

    cmdpkt_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .dat_ready (dat_ready),
        .in_ready  (in_ready),
        .dat_valid (dat_valid),
        .dat_byte  (dat_byte),
        .evt       (evt)
    );

    cmdpkt_wr #(
        .NSUB   (NSUB),
        .CFG_W  (CFG_W),
        .LANES  (LANES),
        .VAL_W  (VAL_W),
        .ADDR_W (ADDR_W)
    ) i_wr (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .ncar_we   (ncar_we),
        .ncar_val  (ncar_val),
        .guard_we  (guard_we),
        .guard_val (guard_val),
        .tbl_we    (tbl_we),
        .tbl_addr  (tbl_addr),
        .tbl_cfg   (tbl_cfg),
        .bad_id    (bad_id)
    );

endmodule

// File: rtl/cmdpkt_chk.sv
module cmdpkt_chk #(
    parameter int NSUB   = 256,
    parameter int LANES  = 2,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              dat_valid,
    input logic              ncar_we,
    input logic              guard_we,
    input logic [LANES-1:0]  tbl_we,
    input logic [ADDR_W-1:0] tbl_addr,
    input logic              bad_id
);

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ncar_we, guard_we, |tbl_we, bad_id}));                    // R10

    AST_LANE0_FIRST: assert property (@(posedge clk) disable iff (rst)
        (|tbl_we) |-> tbl_we[0]);                                             // R4

    AST_EDGE_SUPPRESS: assert property (@(posedge clk) disable iff (rst)
        ((|tbl_we) && tbl_addr == ADDR_W'(NSUB - 1)) |-> tbl_we[LANES-1:1] == '0); // R5

    AST_FWD_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        dat_valid |-> in_valid);                                              // R6

    AST_NC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ncar_we |-> $past(in_valid && in_ready));                             // R2

    AST_GD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        guard_we |-> $past(in_valid && in_ready));                            // R3

    AST_BAD_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bad_id |-> $past(in_valid && in_ready));                              // R8

endmodule

bind cmdpkt_parser cmdpkt_chk #(
    .NSUB   (NSUB),
    .LANES  (LANES),
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .dat_valid (dat_valid),
    .ncar_we   (ncar_we),
    .guard_we  (guard_we),
    .tbl_we    (tbl_we),
    .tbl_addr  (tbl_addr),
    .bad_id    (bad_id)
);

// File: tb/test_cmdpkt_parser.sv
`timescale 1ns/1ps
module test_cmdpkt_parser;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       dat_valid;
    logic [7:0] dat_byte;
    logic       dat_ready = 1'b1;
    logic       ncar_we;
    logic [8:0] ncar_val;
    logic       guard_we;
    logic [8:0] guard_val;
    logic [1:0] tbl_we;
    logic [7:0] tbl_addr;
    logic [7:0] tbl_cfg;
    logic       bad_id;

    int errors = 0;
    int checks = 0;
    logic stall_en = 1'b0;
    logic [31:0] exp_q[$];
    string       req_q[$];

    always #4 clk = ~clk;

    cmdpkt_parser i_cmdpkt_parser (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .dat_valid(dat_valid),
        .dat_byte(dat_byte), .dat_ready(dat_ready), .ncar_we(ncar_we),
        .ncar_val(ncar_val), .guard_we(guard_we), .guard_val(guard_val),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_cfg(tbl_cfg), .bad_id(bad_id)
    );

    // item kinds in bits [31:28]: 1 count, 2 guard, 3 table, 4 payload, 5 bad id
    function automatic logic [31:0] mk(input logic [3:0] k, input logic [27:0] p);
        return {k, p};
    endfunction

    task automatic push(input logic [31:0] v, input string r);
        exp_q.push_back(v);
        req_q.push_back(r);
    endtask

    task automatic got(input logic [31:0] v);
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R10 unexpected item actual=%h expected=none", v);
        end else begin
            logic [31:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            if (v !== e) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", r, v, e);
            end
        end
    endtask

    // dat_ready pattern, changed well away from both edges
    initial begin
        int ph = 0;
        forever begin
            @(posedge clk);
            #2;
            ph++;
            dat_ready = stall_en ? ((ph % 3) != 1) : 1'b1;
        end
    end

    // monitor: samples one ns before each rising edge
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst) begin
                if (ncar_we)  got(mk(4'h1, {19'd0, ncar_val}));
                if (guard_we) got(mk(4'h2, {19'd0, guard_val}));
                if (|tbl_we)  got(mk(4'h3, {10'd0, tbl_we, tbl_addr, tbl_cfg}));
                if (bad_id)   got(mk(4'h5, 28'd0));
                if (dat_valid) begin
                    checks++;
                    if (in_ready !== dat_ready) begin
                        errors++;
                        $display("FAIL R6 in_ready actual=%b expected=%b", in_ready, dat_ready);
                    end
                    if (dat_ready) got(mk(4'h4, {20'd0, dat_byte}));
                end
            end
        end
    end

    task automatic send(input logic [7:0] b, input logic last);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic blk_ncar(input logic [15:0] v, input logic last);
        send(8'h01, 1'b0);
        send(v[7:0], 1'b0);
        push(mk(4'h1, {19'd0, v[8:0]}), "R2");
        send(v[15:8], last);
    endtask

    task automatic blk_guard(input logic [15:0] v, input logic last);
        send(8'h03, 1'b0);
        send(v[7:0], 1'b0);
        push(mk(4'h2, {19'd0, v[8:0]}), "R3");
        send(v[15:8], last);
    endtask

    task automatic mod_item(input logic [7:0] a, input logic [7:0] c, input logic last);
        logic [1:0] we;
        we = (a == 8'hFF) ? 2'b01 : 2'b11;
        send(a, 1'b0);
        push(mk(4'h3, {10'd0, we, a, c}), (a == 8'hFF) ? "R5" : "R4");
        send(c, last);
    endtask

    task automatic blk_data(input int n, input logic [7:0] seed, input logic last);
        send(8'h04, 1'b0);
        send(8'(n), 1'b0);
        for (int i = 0; i < n; i++) begin
            push(mk(4'h4, {20'd0, 8'(seed + 8'(i * 7))}), "R6");
            send(8'(seed + 8'(i * 7)), last && (i == n - 1));
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #3;
        checks++;
        if (in_ready !== 1'b1 || ncar_we || guard_we || tbl_we != 0 || bad_id || dat_valid) begin
            errors++;
            $display("FAIL R1 reset state actual=%b%b%b%b%b%b expected=100000",
                     in_ready, ncar_we, guard_we, |tbl_we, bad_id, dat_valid);
        end

        // mixed packet: settings, table, payload (R2 R3 R4 R5 R6 R10)
        blk_ncar(16'h0100, 1'b0);
        blk_guard(16'h0040, 1'b0);
        send(8'h02, 1'b0);
        send(8'd2, 1'b0);
        mod_item(8'h10, 8'hA5, 1'b0);
        mod_item(8'hFF, 8'h3C, 1'b0);
        blk_data(5, 8'h11, 1'b1);

        // payload-only packet under back-pressure (R6)
        stall_en = 1'b1;
        blk_data(8, 8'h80, 1'b1);
        stall_en = 1'b0;

        // settings-only packet (R3)
        blk_guard(16'h0100, 1'b1);

        // zero counts end the block (R7)
        send(8'h02, 1'b0);
        send(8'h00, 1'b0);
        blk_ncar(16'h0034, 1'b0);
        send(8'h04, 1'b0);
        send(8'h00, 1'b0);
        mod_item_pkt: begin
            send(8'h02, 1'b0);
            send(8'd1, 1'b0);
            mod_item(8'hFE, 8'h96, 1'b1);
        end

        // unknown identifier drops the rest of the packet (R8)
        push(mk(4'h5, 28'd0), "R8");
        send(8'h09, 1'b0);
        send(8'h04, 1'b0);
        send(8'h02, 1'b0);
        send(8'hAA, 1'b0);
        send(8'hBB, 1'b1);
        blk_ncar(16'h0007, 1'b1);

        // packet-last cuts a payload block short (R9)
        send(8'h04, 1'b0);
        send(8'd5, 1'b0);
        push(mk(4'h4, {20'd0, 8'h21}), "R9");
        send(8'h21, 1'b0);
        push(mk(4'h4, {20'd0, 8'h22}), "R9");
        send(8'h22, 1'b1);
        blk_ncar(16'h0055, 1'b1);

        // packet-last cuts a count field short (R9)
        send(8'h01, 1'b0);
        send(8'h22, 1'b1);
        blk_guard(16'h0010, 1'b1);

        // unknown identifier carrying the last flag (R8 R9)
        push(mk(4'h5, 28'd0), "R8");
        send(8'h00, 1'b1);
        blk_ncar(16'h01FF, 1'b1);

        repeat (5) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R10 pending items actual=%0d expected=0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule